// File: doc/BRIEF.md
# Address Translation Cache with Access Protection

This block turns a 32-bit logical address into a physical address through a small, fully associative cache of page mappings. Each access presents a logical address, a 3-bit function code (bit 2 high means supervisor mode) and a write flag. In the same cycle the block answers with a physical address, an accepted or aborted status, a miss flag, a per-page cache-inhibit output and two history reports. An external requester uses these reports to update page descriptors in memory. Because the answer is combinational, the bus side can start its cycle in the same clock with no added translation delay. It can also cancel the cycle before the address strobe.

Two ways skip the cache. An external disable input passes every address through unchanged. Two transparent windows, each matched on the top address byte under a mask, also pass addresses through unchanged. Both bypasses are free of protection faults. Mappings are written one per cycle through a fill port. A single flush pulse invalidates them all. Pages are fixed at 4 KiB, and the page number is tagged together with the function code. Table walking is not part of the block: a miss is only reported.

Top module: `xlat_cache`

## Requirements
- R1: An accepted access that hits a cache entry drives `phys_addr` = {stored physical page, `acc_laddr[11:0]`} with `acc_ok`=1 in the same cycle it is presented.
- R2: A valid access that takes no bypass and finds no entry raises `acc_miss` and `acc_abort` in the same cycle. Whenever an access is not translated by an entry (miss, fault, bypass or `acc_valid`=0), `phys_addr` equals `acc_laddr`. With `acc_valid`=0, `acc_ok`, `acc_miss` and `acc_abort` are all 0.
- R3: While `xlat_off`=1, a valid access is accepted with `phys_addr`=`acc_laddr`, even if a faulting entry matches. It raises no abort, no cache-inhibit and no history report.
- R4: Window i (i = 0, 1) matches when `win_en[i]`=1 and (`acc_laddr[31:24]` & ~mask_i) == (base_i & ~mask_i). Base_i and mask_i are bits [8i+7:8i] of `win_base` and `win_mask`. A matching access passes through untranslated and is never aborted, and a window takes priority over a matching entry.
- R5: A write that hits an entry filled with write-protect set is aborted. A read of that entry is accepted.
- R6: An access with `acc_fc[2]`=0 that hits an entry filled with supervisor-only set is aborted. The same access with `acc_fc[2]`=1 is accepted.
- R7: `acc_ci` is 1 exactly for accepted, entry-translated accesses whose entry was filled with cache-inhibit set.
- R8: An entry matches only when both the page number (`acc_laddr[31:12]`) and all three function-code bits are equal to the ones it was filled with.
- R9: The first accepted, entry-translated access to an entry since its fill raises `hist_used_set`. Later ones do not. Aborted accesses leave the history unchanged.
- R10: An accepted, entry-translated write to an entry whose modified bit is clear raises `hist_mod_set`, and the bit is then set. The bit starts as `fill_mod` at fill time.
- R11: A `flush` pulse invalidates every entry from the next cycle on. A fill in the same cycle as a flush is dropped.
- R12: A fill takes effect on the next cycle. A fill whose page and function code match a valid entry rewrites that entry in place. Any other fill goes to slot 0, 1, … 21 in turn, wrapping back to 0, so the 23rd distinct fill after reset evicts the first. Reset clears all entries and the slot pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_laddr | input | 32 | Logical address |
| acc_fc | input | 3 | Function code, bit 2 = supervisor |
| acc_write | input | 1 | Access is a write |
| xlat_off | input | 1 | External translation disable |
| win_en | input | 2 | Transparent window enables |
| win_base | input | 16 | Window base bytes, window i at [8i+7:8i] |
| win_mask | input | 16 | Window ignore masks, window i at [8i+7:8i] |
| flush | input | 1 | Invalidate all entries |
| fill_valid | input | 1 | Write one entry |
| fill_lpn | input | 20 | Logical page number of the fill |
| fill_fc | input | 3 | Function code of the fill |
| fill_ppn | input | 20 | Physical page number of the fill |
| fill_wp | input | 1 | Write-protect attribute |
| fill_sup | input | 1 | Supervisor-only attribute |
| fill_ci | input | 1 | Cache-inhibit attribute |
| fill_mod | input | 1 | Initial modified bit |
| phys_addr | output | 32 | Physical address |
| acc_ok | output | 1 | Access accepted |
| acc_miss | output | 1 | No matching entry |
| acc_abort | output | 1 | Access aborted (miss or protection) |
| acc_ci | output | 1 | Cache inhibit for this access |
| hist_used_set | output | 1 | Used bit must be set in the descriptor |
| hist_mod_set | output | 1 | Modified bit must be set in the descriptor |

## Verification
Every access result (`phys_addr`, `acc_ok`, `acc_miss`, `acc_abort`, `acc_ci` and both history reports) is due in the cycle the access is presented. The bench drives inputs on the falling edge and compares one time unit later, before the next rising edge. Fills, flushes and history updates act on the rising edge and show only in the following cycle. The bench model applies them in that order, after the comparison of the current cycle. The directed cases cover eviction order, flush against a same-cycle fill, bypass priority and faults, and a seeded random run mixes all of these.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int FC_W      = 3;
    localparam int WIN_BITS  = 8;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int SUP_BIT   = FC_W - 1;

    typedef struct packed {
        logic [VPN_W-1:0] lpn;
        logic [FC_W-1:0]  fc;
    } tag_t;

    typedef struct packed {
        logic wp;
        logic sup;
        logic ci;
    } attr_t;

    typedef struct packed {
        logic             valid;
        tag_t             tag;
        logic [VPN_W-1:0] ppn;
        attr_t            attr;
        logic             used;
        logic             modif;
    } entry_t;

    function automatic logic prot_fault(attr_t a, logic wr, logic [FC_W-1:0] fc);
        return (a.wp && wr) || (a.sup && !fc[SUP_BIT]);
    endfunction
endpackage

// File: rtl/xlat_window.sv
module xlat_window
    import xlat_pkg::*;
(
    input  logic                en,
    input  logic [WIN_BITS-1:0] base,
    input  logic [WIN_BITS-1:0] mask,
    input  logic [WIN_BITS-1:0] addr_hi,
    output logic                hit
);
    always_comb hit = en && ((addr_hi & ~mask) == (base & ~mask));
endmodule

// File: rtl/xlat_tag_array.sv
module xlat_tag_array
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             fill_en,
    input  tag_t             fill_tag,
    input  logic [VPN_W-1:0] fill_ppn,
    input  attr_t            fill_attr,
    input  logic             fill_mod,
    input  tag_t             look_tag,
    input  logic             upd_en,
    input  logic             upd_write,
    output logic             look_hit,
    output entry_t           look_ent
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

    entry_t                  ents [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0]  look_vec;
    logic [NUM_ENTRIES-1:0]  fill_vec;
    logic [IDX_W-1:0]        look_idx;
    logic [IDX_W-1:0]        fill_idx;
    logic                    fill_match;
    logic [IDX_W-1:0]        rr_ptr;
    logic [IDX_W-1:0]        slot;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign look_vec[g] = ents[g].valid && (ents[g].tag == look_tag);
        assign fill_vec[g] = ents[g].valid && (ents[g].tag == fill_tag);
    end

    always_comb begin
        look_idx   = '0;
        fill_idx   = '0;
        fill_match = 1'b0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (look_vec[i]) look_idx = IDX_W'(i);
            if (fill_vec[i]) begin
                fill_idx   = IDX_W'(i);
                fill_match = 1'b1;
            end
        end
        look_hit = |look_vec;
        look_ent = ents[look_idx];
        slot     = fill_match ? fill_idx : rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
            for (int i = 0; i < NUM_ENTRIES; i++) ents[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ents[i].valid <= 1'b0;
        end else begin
            if (upd_en) begin
                ents[look_idx].used <= 1'b1;
                if (upd_write) ents[look_idx].modif <= 1'b1;
            end
            if (fill_en) begin
                ents[slot] <= '{valid: 1'b1, tag: fill_tag, ppn: fill_ppn,
                                attr: fill_attr, used: 1'b0, modif: fill_mod};
                if (!fill_match) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 22,
    parameter int NUM_WIN     = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         acc_valid,
    input  logic [VA_W-1:0]              acc_laddr,
    input  logic [FC_W-1:0]              acc_fc,
    input  logic                         acc_write,
    input  logic                         xlat_off,
    input  logic [NUM_WIN-1:0]           win_en,
    input  logic [NUM_WIN*WIN_BITS-1:0]  win_base,
    input  logic [NUM_WIN*WIN_BITS-1:0]  win_mask,
    input  logic                         flush,
    input  logic                         fill_valid,
    input  logic [VPN_W-1:0]             fill_lpn,
    input  logic [FC_W-1:0]              fill_fc,
    input  logic [VPN_W-1:0]             fill_ppn,
    input  logic                         fill_wp,
    input  logic                         fill_sup,
    input  logic                         fill_ci,
    input  logic                         fill_mod,
    output logic [VA_W-1:0]              phys_addr,
    output logic                         acc_ok,
    output logic                         acc_miss,
    output logic                         acc_abort,
    output logic                         acc_ci,
    output logic                         hist_used_set,
    output logic                         hist_mod_set
);
    logic [NUM_WIN-1:0] win_hit;
    logic               win_any;
    logic               bypass;
    logic               look_hit;
    entry_t             look_ent;
    logic               fault;
    logic               tr_ok;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        xlat_window u_win (
            .en      (win_en[w]),
            .base    (win_base[w*WIN_BITS +: WIN_BITS]),
            .mask    (win_mask[w*WIN_BITS +: WIN_BITS]),
            .addr_hi (acc_laddr[VA_W-1 -: WIN_BITS]),
            .hit     (win_hit[w])
        );
    end

    xlat_tag_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .fill_en   (fill_valid),
        .fill_tag  ('{lpn: fill_lpn, fc: fill_fc}),
        .fill_ppn  (fill_ppn),
        .fill_attr ('{wp: fill_wp, sup: fill_sup, ci: fill_ci}),
        .fill_mod  (fill_mod),
        .look_tag  ('{lpn: acc_laddr[VA_W-1:PAGE_BITS], fc: acc_fc}),
        .upd_en    (tr_ok),
        .upd_write (acc_write),
        .look_hit  (look_hit),
        .look_ent  (look_ent)
    );

    always_comb begin
        win_any       = |win_hit;
        bypass        = xlat_off || win_any;
        fault         = prot_fault(look_ent.attr, acc_write, acc_fc);
        tr_ok         = acc_valid && !bypass && look_hit && !fault;
        acc_miss      = acc_valid && !bypass && !look_hit;
        acc_abort     = acc_valid && !bypass && (!look_hit || fault);
        acc_ok        = acc_valid && (bypass || (look_hit && !fault));
        acc_ci        = tr_ok && look_ent.attr.ci;
        hist_used_set = tr_ok && !look_ent.used;
        hist_mod_set  = tr_ok && acc_write && !look_ent.modif;
        phys_addr     = tr_ok ? {look_ent.ppn, acc_laddr[PAGE_BITS-1:0]} : acc_laddr;
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic [31:0] acc_laddr,
    input logic [2:0]  acc_fc,
    input logic        acc_write,
    input logic        xlat_off,
    input logic        win_any,
    input logic        flush,
    input logic        fill_valid,
    input logic [31:0] phys_addr,
    input logic        acc_ok,
    input logic        acc_miss,
    input logic        acc_abort,
    input logic        acc_ci,
    input logic        hist_mod_set
);
    AST_OK_XOR_ABORT: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (acc_ok != acc_abort)); // R2
    AST_MISS_ABORTS: assert property (@(posedge clk) disable iff (rst)
        acc_miss |-> acc_abort); // R2
    AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && xlat_off) |-> (acc_ok && !acc_ci && phys_addr == acc_laddr)); // R3
    AST_WIN_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && win_any) |-> (!acc_abort && phys_addr == acc_laddr)); // R4
    AST_CI_TRANSLATED: assert property (@(posedge clk) disable iff (rst)
        acc_ci |-> (acc_ok && !xlat_off && !win_any)); // R7
    AST_MOD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        hist_mod_set |-> (acc_write && acc_ok)); // R10
    AST_MOD_ONCE: assert property (@(posedge clk) disable iff (rst)
        (hist_mod_set && !flush && !fill_valid) |=>
        !(hist_mod_set && $stable(acc_laddr) && $stable(acc_fc))); // R10
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> !(acc_ok && !xlat_off && !win_any)); // R11
endmodule

bind xlat_cache xlat_cache_chk u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_laddr(acc_laddr),
    .acc_fc(acc_fc), .acc_write(acc_write), .xlat_off(xlat_off),
    .win_any(win_any), .flush(flush), .fill_valid(fill_valid),
    .phys_addr(phys_addr), .acc_ok(acc_ok), .acc_miss(acc_miss),
    .acc_abort(acc_abort), .acc_ci(acc_ci), .hist_mod_set(hist_mod_set)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
    localparam int NE = 22;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_write, xlat_off, flush, fill_valid;
    logic [31:0] acc_laddr;
    logic [2:0]  acc_fc, fill_fc;
    logic [1:0]  win_en;
    logic [15:0] win_base, win_mask;
    logic [19:0] fill_lpn, fill_ppn;
    logic        fill_wp, fill_sup, fill_ci, fill_mod;
    logic [31:0] phys_addr;
    logic        acc_ok, acc_miss, acc_abort, acc_ci, hist_used_set, hist_mod_set;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    xlat_cache u0 (.*);

    // reference state
    bit        m_v [NE];
    bit [19:0] m_lpn [NE];
    bit [2:0]  m_fc [NE];
    bit [19:0] m_ppn [NE];
    bit        m_wp [NE], m_sup [NE], m_ci [NE], m_used [NE], m_mod [NE];
    int        m_ptr;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit win_match();
        for (int w = 0; w < 2; w++)
            if (win_en[w] && ((acc_laddr[31:24] & ~win_mask[w*8 +: 8]) ==
                              (win_base[w*8 +: 8] & ~win_mask[w*8 +: 8])))
                return 1'b1;
        return 1'b0;
    endfunction

    function automatic int find(bit [19:0] lpn, bit [2:0] fc);
        for (int i = 0; i < NE; i++)
            if (m_v[i] && m_lpn[i] == lpn && m_fc[i] == fc) return i;
        return -1;
    endfunction

    function automatic bit m_tr_ok(int idx);
        if (!acc_valid || xlat_off || win_match() || idx < 0) return 1'b0;
        return !((m_wp[idx] && acc_write) || (m_sup[idx] && !acc_fc[2]));
    endfunction

    task automatic model_check();
        int  idx = find(acc_laddr[31:12], acc_fc);
        bit  byp = xlat_off || win_match();
        bit  tr  = m_tr_ok(idx);
        bit  e_miss = acc_valid && !byp && idx < 0;
        bit  e_ok   = acc_valid && (byp || tr);
        chk("R1 phys", phys_addr, tr ? {m_ppn[idx], acc_laddr[11:0]} : acc_laddr);
        chk("R2 ok", 32'(acc_ok), 32'(e_ok));
        chk("R2 miss", 32'(acc_miss), 32'(e_miss));
        chk("R2 abort", 32'(acc_abort), 32'(acc_valid && !e_ok));
        chk("R7 ci", 32'(acc_ci), 32'(tr && m_ci[idx]));
        chk("R9 used", 32'(hist_used_set), 32'(tr && !m_used[idx]));
        chk("R10 mod", 32'(hist_mod_set), 32'(tr && acc_write && !m_mod[idx]));
    endtask

    task automatic model_update();
        int idx = find(acc_laddr[31:12], acc_fc);
        if (flush) begin
            for (int i = 0; i < NE; i++) m_v[i] = 0;
            return;
        end
        if (m_tr_ok(idx)) begin
            m_used[idx] = 1;
            if (acc_write) m_mod[idx] = 1;
        end
        if (fill_valid) begin
            int s = find(fill_lpn, fill_fc);
            if (s < 0) begin
                s = m_ptr;
                m_ptr = (m_ptr + 1) % NE;
            end
            m_v[s] = 1; m_lpn[s] = fill_lpn; m_fc[s] = fill_fc; m_ppn[s] = fill_ppn;
            m_wp[s] = fill_wp; m_sup[s] = fill_sup; m_ci[s] = fill_ci;
            m_used[s] = 0; m_mod[s] = fill_mod;
        end
    endtask

    task automatic idle();
        acc_valid = 0; acc_write = 0; acc_laddr = 0; acc_fc = 3'd1;
        xlat_off = 0; win_en = 0; win_base = 0; win_mask = 0;
        flush = 0; fill_valid = 0; fill_lpn = 0; fill_fc = 0; fill_ppn = 0;
        fill_wp = 0; fill_sup = 0; fill_ci = 0; fill_mod = 0;
    endtask

    task automatic settle(); #1; endtask

    task automatic finish_cycle();
        settle();
        model_check();
        model_update();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_fill(bit [19:0] lpn, bit [2:0] fc, bit [19:0] ppn,
                           bit wp, bit sup, bit ci, bit md);
        fill_valid = 1; fill_lpn = lpn; fill_fc = fc; fill_ppn = ppn;
        fill_wp = wp; fill_sup = sup; fill_ci = ci; fill_mod = md;
        finish_cycle();
    endtask

    task automatic set_acc(bit [31:0] la, bit [2:0] fc, bit wr);
        acc_valid = 1; acc_laddr = la; acc_fc = fc; acc_write = wr;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: act=running exp=finished");
        summary();
    end

    initial begin
        idle();
        rst = 1;
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R2 reset state: empty cache misses
        set_acc(32'h0010_0123, 3'd1, 0);
        settle(); chk("R2 reset miss", 32'(acc_miss), 1);
        finish_cycle();

        // R1 R9 R10 basic hit and history
        do_fill(20'h00100, 3'd1, 20'hABCDE, 0, 0, 0, 0);
        set_acc(32'h0010_0123, 3'd1, 0);
        settle(); chk("R1 hit phys", phys_addr, 32'hABCD_E123);
        chk("R9 first use", 32'(hist_used_set), 1);
        finish_cycle();
        set_acc(32'h0010_0FFF, 3'd1, 0);
        settle(); chk("R9 second use", 32'(hist_used_set), 0);
        finish_cycle();
        set_acc(32'h0010_0004, 3'd1, 1);
        settle(); chk("R10 first write", 32'(hist_mod_set), 1);
        finish_cycle();
        set_acc(32'h0010_0008, 3'd1, 1);
        settle(); chk("R10 second write", 32'(hist_mod_set), 0);
        finish_cycle();

        // R8 function code is part of the tag
        set_acc(32'h0010_0123, 3'd2, 0);
        settle(); chk("R8 other fc", 32'(acc_miss), 1);
        finish_cycle();

        // R5 write protect, R7 cache inhibit
        do_fill(20'h00200, 3'd5, 20'h11111, 1, 0, 1, 0);
        set_acc(32'h0020_0010, 3'd5, 1);
        settle(); chk("R5 wp write", 32'(acc_abort), 1);
        chk("R9 no history on abort", 32'(hist_used_set), 0);
        finish_cycle();
        set_acc(32'h0020_0010, 3'd5, 0);
        settle(); chk("R5 wp read", 32'(acc_ok), 1);
        chk("R7 ci", 32'(acc_ci), 1);
        finish_cycle();

        // R6 supervisor only
        do_fill(20'h00300, 3'd1, 20'h22222, 0, 1, 0, 0);
        do_fill(20'h00300, 3'd5, 20'h33333, 0, 1, 0, 0);
        set_acc(32'h0030_0000, 3'd1, 0);
        settle(); chk("R6 user on sup page", 32'(acc_abort), 1);
        finish_cycle();
        set_acc(32'h0030_0000, 3'd5, 0);
        settle(); chk("R6 sup on sup page", 32'(acc_ok), 1);
        finish_cycle();

        // R3 disable overrides a faulting entry
        set_acc(32'h0020_0040, 3'd5, 1);
        xlat_off = 1;
        settle(); chk("R3 off ok", 32'(acc_ok), 1);
        chk("R3 off phys", phys_addr, 32'h0020_0040);
        finish_cycle();

        // R4 window over a cache entry with wp
        set_acc(32'h0020_0040, 3'd5, 1);
        win_en = 2'b10; win_base = 16'h0300; win_mask = 16'h0300;
        settle(); chk("R4 window passthru", phys_addr, 32'h0020_0040);
        chk("R4 window no abort", 32'(acc_abort), 0);
        finish_cycle();
        set_acc(32'h0420_0040, 3'd5, 0);
        win_en = 2'b10; win_base = 16'h0300; win_mask = 16'h0300;
        settle(); chk("R4 window mismatch", 32'(acc_miss), 1);
        finish_cycle();

        // R12 in-place rewrite
        do_fill(20'h00100, 3'd1, 20'h55555, 0, 0, 0, 1);
        set_acc(32'h0010_0321, 3'd1, 0);
        settle(); chk("R12 rewrite", phys_addr, 32'h5555_5321);
        finish_cycle();

        // R11 flush with a same-cycle fill
        flush = 1;
        fill_valid = 1; fill_lpn = 20'h00700; fill_fc = 3'd1; fill_ppn = 20'h77777;
        finish_cycle();
        set_acc(32'h0010_0321, 3'd1, 0);
        settle(); chk("R11 flushed", 32'(acc_miss), 1);
        finish_cycle();
        set_acc(32'h0070_0000, 3'd1, 0);
        settle(); chk("R11 fill dropped", 32'(acc_miss), 1);
        finish_cycle();

        // R12 round robin: 23 distinct fills evict the first one written
        for (int i = 0; i < NE + 1; i++)
            do_fill(20'h01000 + 20'(i), 3'd2, 20'h40000 + 20'(i), 0, 0, 0, 0);
        set_acc(32'h0100_0000 + (32'(m_ptr == 0 ? 0 : 0) << 12), 3'd2, 0);
        settle(); chk("R12 oldest evicted", 32'(acc_miss), 1);
        finish_cycle();
        set_acc(32'h0101_6000, 3'd2, 0);
        settle(); chk("R12 newest present", phys_addr, 32'h4001_6000);
        finish_cycle();

        // constrained random mix
        void'($urandom(32'd2024));
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 32);
            bit [2:0] fcs [4] = '{3'd1, 3'd2, 3'd5, 3'd6};
            if (r == 0) flush = 1;
            if (r < 10) begin
                fill_valid = 1;
                fill_lpn = 20'h00100 + 20'($urandom % 10);
                fill_fc  = fcs[$urandom % 4];
                fill_ppn = 20'($urandom);
                fill_wp  = ($urandom % 4) == 0;
                fill_sup = ($urandom % 4) == 0;
                fill_ci  = ($urandom % 3) == 0;
                fill_mod = ($urandom % 4) == 0;
            end
            if (r != 31) begin
                bit [7:0] hi = (($urandom % 8) == 0) ? 8'h40 : 8'h00;
                set_acc({hi, 4'h0, 20'h00100 + 20'($urandom % 10)} << 0 == 0 ? 32'h0 :
                        {hi, 24'h0} | ((32'h00100 + 32'($urandom % 10)) << 12) |
                        32'($urandom % 4096),
                        fcs[$urandom % 4], 1'($urandom));
            end
            if (($urandom % 32) == 0) xlat_off = 1;
            if (($urandom % 8) == 0) begin
                win_en   = 2'($urandom);
                win_base = {8'h40, 8'($urandom % 2 ? 8'h40 : 8'h80)};
                win_mask = {8'h00, 8'($urandom % 2 ? 8'h00 : 8'h3F)};
            end
            finish_cycle();
        end
        summary();
    end
endmodule